// File: doc/BRIEF.md
# Instruction Queue Status Trace Decoder

This block sits on the debug side of a processor and rebuilds the instruction stream from outside the core. The core drives a 2-bit pipe-status code that carries two separate code sets. The code seen when the bus clock rises says how the core's two-stage instruction queue moved. The code seen when the bus clock falls says what execution is doing. The decoder runs on a fast system clock. The capture logic gives it one strobe per bus-clock edge (`rise_stb` or `fall_stb`), together with the code and the program word seen on the data bus for that bus cycle.

From the movement codes the decoder keeps a shadow copy of the queue: a head word, a second stage and a one-word holding buffer. Execution codes are read against that shadow. An instruction-start code produces a one-cycle event that carries the opcode byte, taken from the high or low byte of the shadow head word. An interrupt code produces a one-cycle interrupt-start event, which marks the vector-read cycle.

A page-2 prefix byte (0x18) is reported as an instruction start of its own. The start that follows it is tagged as the remainder of that instruction. An interrupt that arrives between the two is flagged as a protocol error. When the observed codes cannot match the shadow state, a sticky loss-of-sync flag is set, and it stays set until software pulses `resync`.

Top module: `iqt_trace_decoder`

## Requirements
- R1: After reset, every event output is 0, `sync_lost` is 0, and the shadow head, second stage and buffer are all empty.
- R2: A movement code 01 (latch) on `rise_stb` copies `bus_word` into the buffer only if the buffer is empty. Later latch codes leave the buffer unchanged until an advance-from-buffer empties it.
- R3: A movement code 10 (advance from bus) moves the second stage into the head and loads `bus_word` into the second stage.
- R4: A movement code 11 (advance from buffer) moves the second stage into the head, moves the buffer contents (and their validity) into the second stage, and empties the buffer.
- R5: An execution code 10 on `fall_stb` with a valid head gives `ev_start`=1, `ev_odd`=0 and `ev_opcode`=head[15:8]. Code 11 gives `ev_start`=1, `ev_odd`=1 and `ev_opcode`=head[7:0].
- R6: Execution code 01 gives `ev_int`=1. Code 00 (continuation) gives no event.
- R7: A start whose opcode is 0x18, with no prefix pending, gives `ev_prebyte`=1 and makes a prefix pending. The next start gives `ev_page2`=1 and clears the pending state.
- R8: Execution code 01 while a prefix is pending gives `ev_int`=1 together with `ev_proto_err`=1, and clears the pending state.
- R9: An advance-from-buffer with an empty buffer, or a start code with an empty head, sets `sync_lost`. A start code with an empty head gives no `ev_start`. `sync_lost` stays set until `resync`.
- R10: `resync` clears `sync_lost`, all event outputs, the pending prefix and every shadow stage. It overrides any strobe in the same cycle.
- R11: Event outputs are registered. They appear exactly one clock after the `fall_stb` cycle, last one clock, and never follow a cycle without `fall_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resync | input | 1 | Clears sync loss and the shadow state |
| rise_stb | input | 1 | Pipe code is a movement code this cycle |
| fall_stb | input | 1 | Pipe code is an execution code this cycle |
| pipe_code | input | 2 | Captured pipe-status code |
| bus_word | input | 16 | Program word seen on the data bus |
| ev_start | output | 1 | Instruction-start event |
| ev_odd | output | 1 | Start is in the low byte of the head word |
| ev_opcode | output | 8 | Opcode byte of the starting instruction |
| ev_prebyte | output | 1 | Start is a page-2 prefix byte |
| ev_page2 | output | 1 | Start is the remainder of a prefixed instruction |
| ev_int | output | 1 | Interrupt-sequence start event |
| ev_proto_err | output | 1 | Interrupt arrived between prefix and remainder |
| sync_lost | output | 1 | Sticky loss-of-sync flag |

## Verification
The hardest state to reach from the ports is a full buffer that has absorbed a second latch code and then feeds the queue through an advance-from-buffer. The ignored word can only be seen two advances later, as the opcode of a start. A directed sequence builds this case: two latches with different words, one advance-from-buffer, one advance-from-bus, then even and odd starts. A long pseudo-random sweep of interleaved movement codes, execution codes, prefix-heavy data words and occasional resyncs then reaches underruns, blind starts and prefix/interrupt collisions. Each step is checked against a bench model of the queue.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
  typedef enum logic [1:0] {
    MV_NONE    = 2'b00,
    MV_LATCH   = 2'b01,
    MV_ADV_BUS = 2'b10,
    MV_ADV_BUF = 2'b11
  } move_code_t;

  typedef enum logic [1:0] {
    EX_CONT = 2'b00,
    EX_INT  = 2'b01,
    EX_EVEN = 2'b10,
    EX_ODD  = 2'b11
  } exec_code_t;
endpackage

// File: rtl/iqt_shadow_queue.sv
module iqt_shadow_queue
  import iqt_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              mv_stb,
  input  move_code_t        mv_code,
  input  logic [WORD_W-1:0] bus_word,
  output logic [WORD_W-1:0] head_word,
  output logic              head_valid,
  output logic              latch_take,
  output logic              latch_drop,
  output logic              adv_underrun
);
  logic [WORD_W-1:0] s1_word, buf_word;
  logic              s1_valid, buf_valid;
  logic              adv_bus, adv_buf;

  // Movement decode (R2, R3, R4)
  assign latch_take   = mv_stb && (mv_code == MV_LATCH) && !buf_valid;
  assign latch_drop   = mv_stb && (mv_code == MV_LATCH) && buf_valid;
  assign adv_bus      = mv_stb && (mv_code == MV_ADV_BUS);
  assign adv_buf      = mv_stb && (mv_code == MV_ADV_BUF);
  assign adv_underrun = adv_buf && !buf_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_word  <= '0;
      s1_word    <= '0;
      buf_word   <= '0;
      head_valid <= 1'b0;
      s1_valid   <= 1'b0;
      buf_valid  <= 1'b0;
    end else if (resync) begin
      head_valid <= 1'b0;
      s1_valid   <= 1'b0;
      buf_valid  <= 1'b0;
    end else begin
      if (latch_take) begin
        buf_word  <= bus_word;
        buf_valid <= 1'b1;
      end
      if (adv_bus || adv_buf) begin
        head_word  <= s1_word;
        head_valid <= s1_valid;
      end
      if (adv_bus) begin
        s1_word  <= bus_word;
        s1_valid <= 1'b1;
      end
      if (adv_buf) begin
        s1_word   <= buf_word;
        s1_valid  <= buf_valid;
        buf_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iqt_exec_decode.sv
module iqt_exec_decode
  import iqt_pkg::*;
#(
  parameter int               OPC_W   = 8,
  parameter logic [OPC_W-1:0] PREBYTE = 8'h18,
  localparam int              WORD_W  = 2 * OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              ex_stb,
  input  exec_code_t        ex_code,
  input  logic [WORD_W-1:0] head_word,
  input  logic              head_valid,
  output logic              start_blind,
  output logic              prefix_pending,
  output logic              ev_start,
  output logic              ev_odd,
  output logic [OPC_W-1:0]  ev_opcode,
  output logic              ev_prebyte,
  output logic              ev_page2,
  output logic              ev_int,
  output logic              ev_proto_err
);
  // High byte is the even half, low byte the odd half (R5)
  function automatic logic [OPC_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                 input logic odd);
    return odd ? w[OPC_W-1:0] : w[WORD_W-1:OPC_W];
  endfunction

  logic             is_start, is_int;
  logic [OPC_W-1:0] sel_byte;

  assign is_start    = ex_stb && (ex_code == EX_EVEN || ex_code == EX_ODD);
  assign is_int      = ex_stb && (ex_code == EX_INT);
  assign start_blind = is_start && !head_valid;
  assign sel_byte    = pick_byte(head_word, ex_code == EX_ODD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_start       <= 1'b0;
      ev_odd         <= 1'b0;
      ev_opcode      <= '0;
      ev_prebyte     <= 1'b0;
      ev_page2       <= 1'b0;
      ev_int         <= 1'b0;
      ev_proto_err   <= 1'b0;
      prefix_pending <= 1'b0;
    end else if (resync) begin
      ev_start       <= 1'b0;
      ev_prebyte     <= 1'b0;
      ev_page2       <= 1'b0;
      ev_int         <= 1'b0;
      ev_proto_err   <= 1'b0;
      prefix_pending <= 1'b0;
    end else begin
      ev_start     <= 1'b0;
      ev_prebyte   <= 1'b0;
      ev_page2     <= 1'b0;
      ev_int       <= 1'b0;
      ev_proto_err <= 1'b0;
      if (is_int) begin
        ev_int         <= 1'b1;
        ev_proto_err   <= prefix_pending;
        prefix_pending <= 1'b0;
      end else if (is_start && head_valid) begin
        ev_start  <= 1'b1;
        ev_odd    <= (ex_code == EX_ODD);
        ev_opcode <= sel_byte;
        if (prefix_pending) begin
          ev_page2       <= 1'b1;
          prefix_pending <= 1'b0;
        end else if (sel_byte == PREBYTE) begin
          ev_prebyte     <= 1'b1;
          prefix_pending <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iqt_lost_flag.sv
module iqt_lost_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set_a,
  input  logic set_b,
  output logic lost
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lost <= 1'b0;
    else if (clear)            lost <= 1'b0;
    else if (set_a || set_b)   lost <= 1'b1;
  end
endmodule

// File: rtl/iqt_trace_decoder.sv
module iqt_trace_decoder
  import iqt_pkg::*;
#(
  parameter int               OPC_W   = 8,
  parameter logic [OPC_W-1:0] PREBYTE = 8'h18,
  localparam int              WORD_W  = 2 * OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic [1:0]        pipe_code,
  input  logic [WORD_W-1:0] bus_word,
  output logic              ev_start,
  output logic              ev_odd,
  output logic [OPC_W-1:0]  ev_opcode,
  output logic              ev_prebyte,
  output logic              ev_page2,
  output logic              ev_int,
  output logic              ev_proto_err,
  output logic              sync_lost
);
  // Named internal events, brought out for the checker
  logic [WORD_W-1:0] head_word;
  logic              head_valid;
  logic              latch_take, latch_drop, adv_underrun;
  logic              start_blind, prefix_pending;
  move_code_t        mv_code;
  exec_code_t        ex_code;

  assign mv_code = move_code_t'(pipe_code);
  assign ex_code = exec_code_t'(pipe_code);

  iqt_shadow_queue #(.WORD_W(WORD_W)) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .resync       (resync),
    .mv_stb       (rise_stb),
    .mv_code      (mv_code),
    .bus_word     (bus_word),
    .head_word    (head_word),
    .head_valid   (head_valid),
    .latch_take   (latch_take),
    .latch_drop   (latch_drop),
    .adv_underrun (adv_underrun)
  );

  iqt_exec_decode #(.OPC_W(OPC_W), .PREBYTE(PREBYTE)) u_exec (
    .clk            (clk),
    .rst_n          (rst_n),
    .resync         (resync),
    .ex_stb         (fall_stb),
    .ex_code        (ex_code),
    .head_word      (head_word),
    .head_valid     (head_valid),
    .start_blind    (start_blind),
    .prefix_pending (prefix_pending),
    .ev_start       (ev_start),
    .ev_odd         (ev_odd),
    .ev_opcode      (ev_opcode),
    .ev_prebyte     (ev_prebyte),
    .ev_page2       (ev_page2),
    .ev_int         (ev_int),
    .ev_proto_err   (ev_proto_err)
  );

  iqt_lost_flag u_lost (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (resync),
    .set_a (adv_underrun),
    .set_b (start_blind),
    .lost  (sync_lost)
  );
endmodule

// File: rtl/iqt_trace_checker.sv
module iqt_trace_checker #(
  parameter int               OPC_W   = 8,
  parameter logic [OPC_W-1:0] PREBYTE = 8'h18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             resync,
  input logic             fall_stb,
  input logic [1:0]       pipe_code,
  input logic             head_valid,
  input logic             latch_drop,
  input logic             adv_underrun,
  input logic             prefix_pending,
  input logic             ev_start,
  input logic             ev_odd,
  input logic [OPC_W-1:0] ev_opcode,
  input logic             ev_prebyte,
  input logic             ev_page2,
  input logic             ev_int,
  input logic             ev_proto_err,
  input logic             sync_lost
);
  assert_start_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && pipe_code[1] && head_valid && !resync) |=> (ev_start && ev_odd == $past(pipe_code[0])));

  assert_start_int_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start && ev_int));

  assert_prebyte_opcode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prebyte |-> (ev_start && ev_opcode == PREBYTE && !ev_page2));

  assert_page2_needs_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && pipe_code[1] && head_valid && prefix_pending && !resync) |=> ev_page2);

  assert_proto_with_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_proto_err |-> ev_int);

  assert_underrun_sets_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_underrun && !resync) |=> sync_lost);

  assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && !resync) |=> sync_lost);

  assert_latch_drop_no_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_drop && !sync_lost && !resync && !fall_stb) |=> !sync_lost);

  assert_resync_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!sync_lost && !ev_start && !ev_int && !prefix_pending));

  assert_quiet_without_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> (!ev_start && !ev_int && !ev_proto_err));
endmodule

bind iqt_trace_decoder iqt_trace_checker #(.OPC_W(OPC_W), .PREBYTE(PREBYTE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .resync         (resync),
  .fall_stb       (fall_stb),
  .pipe_code      (pipe_code),
  .head_valid     (head_valid),
  .latch_drop     (latch_drop),
  .adv_underrun   (adv_underrun),
  .prefix_pending (prefix_pending),
  .ev_start       (ev_start),
  .ev_odd         (ev_odd),
  .ev_opcode      (ev_opcode),
  .ev_prebyte     (ev_prebyte),
  .ev_page2       (ev_page2),
  .ev_int         (ev_int),
  .ev_proto_err   (ev_proto_err),
  .sync_lost      (sync_lost)
);

// File: tb/iqt_trace_decoder_tb.sv
module iqt_trace_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resync = 1'b0;
  logic        rise_stb = 1'b0;
  logic        fall_stb = 1'b0;
  logic [1:0]  pipe_code = 2'b00;
  logic [15:0] bus_word = 16'h0;
  logic        ev_start, ev_odd, ev_prebyte, ev_page2, ev_int, ev_proto_err, sync_lost;
  logic [7:0]  ev_opcode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iqt_trace_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .resync(resync), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .pipe_code(pipe_code), .bus_word(bus_word),
    .ev_start(ev_start), .ev_odd(ev_odd), .ev_opcode(ev_opcode),
    .ev_prebyte(ev_prebyte), .ev_page2(ev_page2), .ev_int(ev_int),
    .ev_proto_err(ev_proto_err), .sync_lost(sync_lost)
  );

  // Bench model of the shadow queue
  logic [15:0] m_head = 0, m_s1 = 0, m_buf = 0;
  logic m_hv = 0, m_s1v = 0, m_bv = 0, m_pend = 0, m_lost = 0;
  logic e_start, e_odd, e_pre, e_p2, e_int, e_perr;
  logic [7:0] e_opc = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "ev_start", ev_start, e_start);
    if (e_start) begin
      chk(tag, "ev_odd", ev_odd, e_odd);
      chk(tag, "ev_opcode", ev_opcode, e_opc);
    end
    chk(tag, "ev_prebyte", ev_prebyte, e_pre);
    chk(tag, "ev_page2", ev_page2, e_p2);
    chk(tag, "ev_int", ev_int, e_int);
    chk(tag, "ev_proto_err", ev_proto_err, e_perr);
    chk(tag, "sync_lost", sync_lost, m_lost);
  endtask

  task automatic clear_exp();
    e_start = 0; e_odd = 0; e_pre = 0; e_p2 = 0; e_int = 0; e_perr = 0;
  endtask

  task automatic model_rise(input logic [1:0] c, input logic [15:0] w);
    case (c)
      2'b01: if (!m_bv) begin m_buf = w; m_bv = 1; end
      2'b10: begin m_head = m_s1; m_hv = m_s1v; m_s1 = w; m_s1v = 1; end
      2'b11: begin
        if (!m_bv) m_lost = 1;
        m_head = m_s1; m_hv = m_s1v; m_s1 = m_buf; m_s1v = m_bv; m_bv = 0;
      end
      default: ;
    endcase
  endtask

  task automatic do_rise(input logic [1:0] c, input logic [15:0] w, input string tag);
    @(negedge clk);
    rise_stb = 1; pipe_code = c; bus_word = w;
    clear_exp();
    model_rise(c, w);
    @(negedge clk);
    rise_stb = 0;
    check_all(tag);
  endtask

  task automatic do_fall(input logic [1:0] c, input string tag);
    logic [7:0] opc;
    @(negedge clk);
    fall_stb = 1; pipe_code = c;
    clear_exp();
    if (c == 2'b01) begin
      e_int = 1; e_perr = m_pend; m_pend = 0;
    end else if (c[1]) begin
      if (!m_hv) m_lost = 1;
      else begin
        opc = c[0] ? m_head[7:0] : m_head[15:8];
        e_start = 1; e_odd = c[0]; e_opc = opc;
        if (m_pend) begin e_p2 = 1; m_pend = 0; end
        else if (opc == 8'h18) begin e_pre = 1; m_pend = 1; end
      end
    end
    @(negedge clk);
    fall_stb = 0;
    check_all(tag);
  endtask

  task automatic model_resync();
    m_hv = 0; m_s1v = 0; m_bv = 0; m_pend = 0; m_lost = 0;
  endtask

  task automatic do_resync(input string tag);
    @(negedge clk);
    resync = 1;
    clear_exp();
    model_resync();
    @(negedge clk);
    resync = 0;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] lfsr2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    clear_exp();
    check_all("R1");

    // R9: start with empty head after reset
    do_fall(2'b10, "R9");
    chk("R9", "blind start lost", sync_lost, 1);
    do_resync("R10");

    // R3 + R5
    do_rise(2'b10, 16'hA1B2, "R3");
    do_rise(2'b10, 16'hC3D4, "R3");
    do_fall(2'b10, "R5");
    chk("R5", "even opcode", ev_opcode, 8'hA1);
    do_fall(2'b11, "R5");
    chk("R5", "odd opcode", ev_opcode, 8'hB2);

    // R6: interrupt and continuation
    do_fall(2'b01, "R6");
    do_fall(2'b00, "R6");

    // R2 + R4: second latch ignored
    do_rise(2'b01, 16'h5566, "R2");
    do_rise(2'b01, 16'h7788, "R2");
    do_rise(2'b11, 16'h0000, "R4");
    do_rise(2'b10, 16'h99AA, "R3");
    do_fall(2'b10, "R2");
    chk("R2", "latched word kept", ev_opcode, 8'h55);
    do_fall(2'b11, "R4");
    chk("R4", "latched word low", ev_opcode, 8'h66);

    // R4/R9: buffer emptied, so the next advance-from-buffer underruns
    do_rise(2'b11, 16'h0000, "R9");
    chk("R9", "underrun lost", sync_lost, 1);
    do_rise(2'b00, 16'h1234, "R9");

    // R10: resync wins over an underrun in the same cycle
    @(negedge clk);
    resync = 1; rise_stb = 1; pipe_code = 2'b11;
    model_resync(); clear_exp();
    @(negedge clk);
    resync = 0; rise_stb = 0;
    check_all("R10");

    // R7: prefix then remainder
    do_rise(2'b10, 16'h1842, "R3");
    do_rise(2'b10, 16'h1818, "R3");
    do_fall(2'b10, "R7");
    chk("R7", "prebyte flag", ev_prebyte, 1);
    do_fall(2'b11, "R7");
    chk("R7", "page2 flag", ev_page2, 1);

    // R8: interrupt between prefix and remainder
    do_rise(2'b10, 16'h0000, "R3");
    do_fall(2'b10, "R7");
    do_fall(2'b01, "R8");
    chk("R8", "proto err", ev_proto_err, 1);
    do_fall(2'b11, "R8");
    chk("R8", "no page2 after int", ev_page2, 0);

    // R11: a rise strobe alone produces no event
    do_rise(2'b00, 16'hFFFF, "R11");

    // Near-exhaustive pseudo-random sweep
    lfsr = 16'hACE1;
    lfsr2 = 16'h1D2B;
    for (int i = 0; i < 3000; i++) begin
      lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      lfsr2 = {lfsr2[14:0], lfsr2[15] ^ lfsr2[13] ^ lfsr2[12] ^ lfsr2[10]};
      if (lfsr[12:11] == 2'b00) lfsr2[15:8] = 8'h18;
      if (lfsr[13] && lfsr[14]) lfsr2[7:0] = 8'h18;
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: do_rise(lfsr[4:3], lfsr2, "R3");
        3'd3, 3'd4, 3'd5, 3'd6: do_fall(lfsr[6:5], "R5");
        default: if (lfsr[9:7] == 3'd0) do_resync("R10");
                 else do_rise(lfsr[4:3], lfsr2, "R4");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule